// File: doc/BRIEF.md
# Dual-Clock Simple Dual-Port RAM

A word-wide on-chip memory shared by two clock domains. The first port runs on its own clock. In each cycle it can idle, read one word, or write one word. The second port runs on an independent clock and can only read. Each port has an enable, and the first port also has a write strobe. Read data from either port is registered: it appears in the cycle after the edge that sampled the address. A port whose enable is low keeps its output word.

The first port reads back in write-first order. When it writes, its own output shows the word being written on the next cycle. A read on the second port from the location that the first port is writing has no defined result. That window starts at the write edge of the first clock and may stay open until the following edge of that clock. Users must keep the two ports apart during that window, or discard such reads. The storage array has no reset. Each port's output register clears under that port's own synchronous active-low reset.

Top module: `dcsdp_ram`

## Requirements
- R1: When `wp_en` is low, port 1 does nothing, whatever the value of `wp_wr`. The memory is not changed and `wp_rdata` keeps its value.
- R2: When `wp_en` is 1 and `wp_wr` is 0 at a rising edge of `wp_clk`, `wp_rdata` shows the word stored at `wp_addr` from that edge on.
- R3: When `wp_en` and `wp_wr` are both 1 at a rising edge of `wp_clk`, `wp_wdata` is stored at `wp_addr`. A later read from either port returns it.
- R4: During a port 1 write, `wp_rdata` shows the word being written from that edge on (write-first).
- R5: When `rp_en` is 1 at a rising edge of `rp_clk`, `rp_rdata` shows the word stored at `rp_addr` from that edge on.
- R6: When `rp_en` is 0, `rp_rdata` keeps its value.
- R7: A low `wp_rst_n` at an edge of `wp_clk` clears `wp_rdata` to zero, and this takes priority over any command. A low `rp_rst_n` at an edge of `rp_clk` clears `rp_rdata` to zero in the same way. The array contents are not reset.
- R8: A port 2 read from an address that port 1 wrote returns the new word once the write's window has closed. The window lasts one `wp_clk` period from the write edge. Reads inside the window are undefined.
- R9: The two clocks may be unrelated. Port 2 reads of locations that port 1 is not writing stay correct while port 1 is busy.
- R10: All 2^A_BITS addresses are usable, from 0 up to 2^A_BITS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wp_clk | input | 1 | Clock of the read/write port |
| wp_rst_n | input | 1 | Synchronous active-low reset of the port 1 output register |
| wp_en | input | 1 | Port 1 enable |
| wp_wr | input | 1 | Port 1 write strobe; selects write when enabled |
| wp_addr | input | A_BITS | Port 1 address |
| wp_wdata | input | D_BITS | Port 1 write word |
| wp_rdata | output | D_BITS | Port 1 registered read word |
| rp_clk | input | 1 | Clock of the read-only port |
| rp_rst_n | input | 1 | Synchronous active-low reset of the port 2 output register |
| rp_en | input | 1 | Port 2 enable |
| rp_addr | input | A_BITS | Port 2 address |
| rp_rdata | output | D_BITS | Port 2 registered read word |

## Verification
The bench drives a disabled port 1 cycle with the write strobe high. A design that decodes the strobe alone would corrupt the location, and the read that follows exposes it. Back-to-back write and read on one address, and writes whose output is checked directly, catch a read-first output or an extra cycle of latency. The ports run on clocks of 10 ns and 14 ns. Port 2 reads a disjoint region while port 1 writes, then reads the fresh words after the windows close. This catches a design that routes the wrong address or data into the second port. Reads inside a collision window are issued but not scored. Mid-run resets with the enables high show whether reset takes priority.

// File: rtl/dcsdp_pkg.sv
// Package: shared types for the dual-clock simple dual-port RAM.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dcsdp_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } wp_cmd_e;
endpackage

// File: rtl/dcsdp_wp_decode.sv
// Module: dcsdp_wp_decode
// Turns the read/write port's enable and write strobe into one command.
// Assumes both inputs are already synchronous to the port's clock.
module dcsdp_wp_decode
    import dcsdp_pkg::*;
(
    input  logic    en,
    input  logic    wr,
    output wp_cmd_e cmd
);
    // Command decode: enable gates everything, the strobe picks write over read.
    always_comb begin
        if (!en)
            cmd = CMD_IDLE;
        else if (wr)
            cmd = CMD_WRITE;
        else
            cmd = CMD_READ;
    end
endmodule

// File: rtl/dcsdp_store.sv
// Module: dcsdp_store
// Word array with one write port clocked by wclk and two address taps.
// The taps are combinational; the caller registers them per domain.
// Assumes no reset on the array; contents start unspecified.
module dcsdp_store #(
    parameter int A_BITS = 8,
    parameter int D_BITS = 16
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [A_BITS-1:0] waddr,
    input  logic [D_BITS-1:0] wdata,
    input  logic [A_BITS-1:0] tap1_addr,
    input  logic [A_BITS-1:0] tap2_addr,
    output logic [D_BITS-1:0] tap1_data,
    output logic [D_BITS-1:0] tap2_data
);
    localparam int DEPTH = 1 << A_BITS;

    logic [D_BITS-1:0] mem [DEPTH];

    // Array write on the port 1 clock.
    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Address taps feeding the per-port output registers.
    assign tap1_data = mem[tap1_addr];
    assign tap2_data = mem[tap2_addr];
endmodule

// File: rtl/dcsdp_outreg.sv
// Module: dcsdp_outreg
// Registered read word for one port. When WRITE_FIRST is set, a write in
// the same cycle replaces the array word with the incoming word.
// Assumes rst_n is synchronous to clk.
module dcsdp_outreg #(
    parameter int D_BITS      = 16,
    parameter bit WRITE_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              byp_sel,
    input  logic [D_BITS-1:0] byp_data,
    input  logic [D_BITS-1:0] arr_data,
    output logic [D_BITS-1:0] q
);
    logic [D_BITS-1:0] next_word;

    generate
        if (WRITE_FIRST) begin : g_wf
            // Select the written word over the stored one during a write.
            assign next_word = byp_sel ? byp_data : arr_data;
        end else begin : g_plain
            // Read-only port: always the stored word.
            logic unused_byp;
            assign unused_byp = byp_sel ^ (^byp_data);
            assign next_word  = arr_data;
        end
    endgenerate

    // Output register: reset first, then load on enable, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= next_word;
    end
endmodule

// File: rtl/dcsdp_ram.sv
// Module: dcsdp_ram (top)
// Dual-clock RAM: port 1 reads or writes on wp_clk, port 2 reads on rp_clk.
// Reads have one cycle of latency. Port 1 is write-first. A port 2 read of
// an address that port 1 writes is undefined for one wp_clk period.
module dcsdp_ram
    import dcsdp_pkg::*;
#(
    parameter int A_BITS = 8,
    parameter int D_BITS = 16
) (
    input  logic              wp_clk,
    input  logic              wp_rst_n,
    input  logic              wp_en,
    input  logic              wp_wr,
    input  logic [A_BITS-1:0] wp_addr,
    input  logic [D_BITS-1:0] wp_wdata,
    output logic [D_BITS-1:0] wp_rdata,
    input  logic              rp_clk,
    input  logic              rp_rst_n,
    input  logic              rp_en,
    input  logic [A_BITS-1:0] rp_addr,
    output logic [D_BITS-1:0] rp_rdata
);
    wp_cmd_e           wp_cmd;
    logic              wp_we;
    logic              wp_load;
    logic [D_BITS-1:0] tap1_data;
    logic [D_BITS-1:0] tap2_data;

    dcsdp_wp_decode u_dec (
        .en  (wp_en),
        .wr  (wp_wr),
        .cmd (wp_cmd)
    );

    // Command to strobes: both read and write refresh the port 1 output.
    assign wp_we   = (wp_cmd == CMD_WRITE);
    assign wp_load = (wp_cmd != CMD_IDLE);

    dcsdp_store #(.A_BITS(A_BITS), .D_BITS(D_BITS)) u_store (
        .wclk      (wp_clk),
        .we        (wp_we),
        .waddr     (wp_addr),
        .wdata     (wp_wdata),
        .tap1_addr (wp_addr),
        .tap2_addr (rp_addr),
        .tap1_data (tap1_data),
        .tap2_data (tap2_data)
    );

    dcsdp_outreg #(.D_BITS(D_BITS), .WRITE_FIRST(1'b1)) u_wp_out (
        .clk      (wp_clk),
        .rst_n    (wp_rst_n),
        .load     (wp_load),
        .byp_sel  (wp_we),
        .byp_data (wp_wdata),
        .arr_data (tap1_data),
        .q        (wp_rdata)
    );

    dcsdp_outreg #(.D_BITS(D_BITS), .WRITE_FIRST(1'b0)) u_rp_out (
        .clk      (rp_clk),
        .rst_n    (rp_rst_n),
        .load     (rp_en),
        .byp_sel  (1'b0),
        .byp_data ('0),
        .arr_data (tap2_data),
        .q        (rp_rdata)
    );
endmodule

// File: rtl/dcsdp_ram_chk.sv
// Module: dcsdp_ram_chk
// Port-level properties of dcsdp_ram, attached with bind below.
// Assumes each port is checked only on its own clock and reset.
module dcsdp_ram_chk #(
    parameter int A_BITS = 8,
    parameter int D_BITS = 16
) (
    input logic              wp_clk,
    input logic              wp_rst_n,
    input logic              wp_en,
    input logic              wp_wr,
    input logic [A_BITS-1:0] wp_addr,
    input logic [D_BITS-1:0] wp_wdata,
    input logic [D_BITS-1:0] wp_rdata,
    input logic              rp_clk,
    input logic              rp_rst_n,
    input logic              rp_en,
    input logic [D_BITS-1:0] rp_rdata
);
    AST_WP_IDLE_HOLD: assert property (@(posedge wp_clk) disable iff (!wp_rst_n)
        !wp_en |=> $stable(wp_rdata)); // R1
    AST_WP_WRITE_FIRST: assert property (@(posedge wp_clk) disable iff (!wp_rst_n)
        (wp_en && wp_wr) |=> (wp_rdata == $past(wp_wdata))); // R4
    AST_WP_READ_AFTER_WRITE: assert property (@(posedge wp_clk) disable iff (!wp_rst_n)
        ((wp_en && wp_wr) ##1 (wp_en && !wp_wr && wp_addr == $past(wp_addr)))
        |=> (wp_rdata == $past(wp_wdata, 2))); // R3
    AST_RP_IDLE_HOLD: assert property (@(posedge rp_clk) disable iff (!rp_rst_n)
        !rp_en |=> $stable(rp_rdata)); // R6
    AST_WP_RESET_CLEAR: assert property (@(posedge wp_clk)
        !wp_rst_n |=> (wp_rdata == '0)); // R7
    AST_RP_RESET_CLEAR: assert property (@(posedge rp_clk)
        !rp_rst_n |=> (rp_rdata == '0)); // R7
endmodule

bind dcsdp_ram dcsdp_ram_chk #(.A_BITS(A_BITS), .D_BITS(D_BITS)) u_chk (
    .wp_clk   (wp_clk),
    .wp_rst_n (wp_rst_n),
    .wp_en    (wp_en),
    .wp_wr    (wp_wr),
    .wp_addr  (wp_addr),
    .wp_wdata (wp_wdata),
    .wp_rdata (wp_rdata),
    .rp_clk   (rp_clk),
    .rp_rst_n (rp_rst_n),
    .rp_en    (rp_en),
    .rp_rdata (rp_rdata)
);

// File: tb/tb_dcsdp_ram.sv
// Bench: scoreboard per port. Driver tasks push expected words with tags.
// Monitors pop and compare 2 ns after each edge of the port's clock.
module tb_dcsdp_ram;
    localparam int A = 8;
    localparam int D = 16;
    localparam int TOP = (1 << A) - 1;

    logic         wp_clk = 1'b0;
    logic         rp_clk = 1'b0;
    logic         wp_rst_n = 1'b0;
    logic         rp_rst_n = 1'b0;
    logic         wp_en = 1'b0;
    logic         wp_wr = 1'b0;
    logic [A-1:0] wp_addr = '0;
    logic [D-1:0] wp_wdata = '0;
    logic [D-1:0] wp_rdata;
    logic         rp_en = 1'b0;
    logic [A-1:0] rp_addr = '0;
    logic [D-1:0] rp_rdata;

    int checks = 0;
    int errors = 0;

    logic [D-1:0] mdl [1 << A];
    logic [D-1:0] e1 = '0;
    logic [D-1:0] e2 = '0;

    logic [D-1:0] q1v[$];
    string        q1t[$];
    logic [D-1:0] q2v[$];
    string        q2t[$];
    bit           q2s[$];

    always #5 wp_clk = ~wp_clk;
    always #7 rp_clk = ~rp_clk;

    dcsdp_ram #(.A_BITS(A), .D_BITS(D)) dut (
        .wp_clk(wp_clk), .wp_rst_n(wp_rst_n), .wp_en(wp_en), .wp_wr(wp_wr),
        .wp_addr(wp_addr), .wp_wdata(wp_wdata), .wp_rdata(wp_rdata),
        .rp_clk(rp_clk), .rp_rst_n(rp_rst_n), .rp_en(rp_en),
        .rp_addr(rp_addr), .rp_rdata(rp_rdata)
    );

    function automatic logic [D-1:0] pat(int a, int salt);
        return D'((a * 16'h9e3) ^ (salt * 16'h1357) ^ 16'h5a5a);
    endfunction

    task automatic check(bit ok, string tag, logic [D-1:0] act, logic [D-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Port 1 driver: one command per wp_clk cycle, expected word queued.
    task automatic wp_op(bit en, bit wr, int a, logic [D-1:0] d, string tag);
        @(negedge wp_clk);
        wp_rst_n = 1'b1;
        wp_en = en; wp_wr = wr; wp_addr = A'(a); wp_wdata = d;
        if (en) begin
            if (wr) begin
                mdl[a] = d;
                e1 = d;
            end else begin
                e1 = mdl[a];
            end
        end
        q1v.push_back(e1);
        q1t.push_back(tag);
    endtask

    // Port 1 reset cycle with a live command, to check reset priority (R7).
    task automatic wp_reset_op(int a);
        @(negedge wp_clk);
        wp_rst_n = 1'b0;
        wp_en = 1'b1; wp_wr = 1'b0; wp_addr = A'(a);
        e1 = '0;
        q1v.push_back(e1);
        q1t.push_back("R7");
    endtask

    task automatic wp_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wp_clk);
            wp_rst_n = 1'b1;
            wp_en = 1'b0; wp_wr = 1'b0;
        end
    endtask

    // Port 2 driver: expected word queued, or marked unscored when skip is set.
    task automatic rp_op(bit en, int a, bit skip, string tag);
        @(negedge rp_clk);
        rp_rst_n = 1'b1;
        rp_en = en; rp_addr = A'(a);
        if (en) e2 = mdl[a];
        q2v.push_back(e2);
        q2t.push_back(tag);
        q2s.push_back(skip);
    endtask

    task automatic rp_reset_op(int a);
        @(negedge rp_clk);
        rp_rst_n = 1'b0;
        rp_en = 1'b1; rp_addr = A'(a);
        e2 = '0;
        q2v.push_back(e2);
        q2t.push_back("R7");
        q2s.push_back(1'b0);
    endtask

    task automatic rp_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rp_clk);
            rp_rst_n = 1'b1;
            rp_en = 1'b0;
        end
    endtask

    // Port 1 monitor.
    initial begin
        forever begin
            @(posedge wp_clk);
            #2;
            if (q1v.size() > 0) begin
                logic [D-1:0] v;
                string t;
                v = q1v.pop_front();
                t = q1t.pop_front();
                check(wp_rdata === v, t, wp_rdata, v);
            end
        end
    end

    // Port 2 monitor; collision-window reads are popped without scoring.
    initial begin
        forever begin
            @(posedge rp_clk);
            #2;
            if (q2v.size() > 0) begin
                logic [D-1:0] v;
                string t;
                bit s;
                v = q2v.pop_front();
                t = q2t.pop_front();
                s = q2s.pop_front();
                if (!s) check(rp_rdata === v, t, rp_rdata, v);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R7: both outputs clear under reset.
        repeat (4) @(negedge wp_clk);
        @(negedge rp_clk);
        wp_rst_n = 1'b1;
        rp_rst_n = 1'b1;
        @(negedge wp_clk);
        check(wp_rdata == '0, "R7", wp_rdata, '0);
        check(rp_rdata == '0, "R7", rp_rdata, '0);

        // R3/R4/R10: write 0..15 and the top address; output shows write data.
        for (int a = 0; a < 16; a++) wp_op(1, 1, a, pat(a, 1), "R4");
        wp_op(1, 1, TOP, pat(TOP, 1), "R10");
        for (int a = 32; a < 48; a++) wp_op(1, 1, a, pat(a, 2), "R4");
        // R2: read back, including address 0 and the top address.
        for (int a = 15; a >= 0; a--) wp_op(1, 0, a, '0, "R2");
        wp_op(1, 0, TOP, '0, "R10");
        // R1: disabled cycle with strobe high must not write or change output.
        wp_op(0, 1, 3, 16'hdead, "R1");
        wp_op(0, 0, 7, 16'hbeef, "R1");
        wp_op(1, 0, 3, '0, "R1");
        // R3: back-to-back write then read of the same address.
        wp_op(1, 1, 9, 16'h1234, "R4");
        wp_op(1, 0, 9, '0, "R3");
        wp_op(1, 1, 9, 16'h4321, "R4");
        wp_op(1, 1, 10, 16'h0f0f, "R4");
        wp_op(1, 0, 9, '0, "R3");
        wp_idle(3);

        // R5/R6/R8: port 2 reads with port 1 idle.
        for (int a = 0; a < 16; a++) rp_op(1, a, 0, "R8");
        rp_op(1, TOP, 0, "R10");
        rp_op(0, 5, 0, "R6");
        rp_op(0, 6, 0, "R6");
        rp_op(1, 9, 0, "R5");
        rp_idle(2);

        // R9: port 1 writes 16..31 while port 2 reads the disjoint 32..47.
        fork
            begin
                for (int a = 16; a < 32; a++) wp_op(1, 1, a, pat(a, 3), "R4");
                wp_idle(2);
            end
            begin
                for (int a = 32; a < 48; a++) rp_op(1, a, 0, "R9");
                rp_idle(2);
            end
        join
        // R8: the fresh words once their windows are closed.
        for (int a = 16; a < 32; a++) rp_op(1, a, 0, "R8");
        rp_idle(2);

        // R8: collision on address 40; reads during writes are not scored.
        fork
            begin
                for (int i = 0; i < 6; i++) wp_op(1, 1, 40, pat(40, 10 + i), "R4");
                wp_idle(3);
            end
            begin
                for (int i = 0; i < 4; i++) rp_op(1, 40, 1, "R8");
                rp_idle(1);
            end
        join
        rp_idle(2);
        rp_op(1, 40, 0, "R8");
        rp_idle(2);

        // R7: resets taking priority over live commands.
        wp_op(1, 0, 9, '0, "R2");
        wp_reset_op(9);
        wp_op(0, 0, 9, '0, "R1");
        wp_op(1, 0, 9, '0, "R2");
        wp_idle(2);
        rp_op(1, 9, 0, "R5");
        rp_reset_op(9);
        rp_op(0, 9, 0, "R6");
        rp_op(1, 9, 0, "R5");
        rp_idle(3);
        wp_idle(3);

        finish_run();
    end
endmodule